// File: doc/BRIEF.md
# Byte-Lane Packing SRAM Access Controller

This block sits between a 20-bit processor data path and an external asynchronous static RAM. It drives a 16-bit address and an active-low chip select and write enable. The data bus is split into an output value, an output enable for the pad driver, and an input value. The core raises a one-clock request carrying the direction, the access mode, a base address and, for writes, a 20-bit value. When the access has completed, the block answers with a single-clock done pulse.

Two access modes exist. In word mode one memory cycle moves the whole 20-bit value. In three-byte mode the value travels through an internal holding register as three consecutive 8-bit cycles on the low byte lane. This lets a 20-bit word live in a byte-wide memory. Every memory cycle lasts a fixed, parameterised number of clocks. The write strobe sits inside the cycle, so address and data are settled before the strobe falls and are still held when it rises.

Top module: `sram_byteword_ctrl`

## Requirements
- R1: After reset, chip select and write enable are high (inactive), the data output enable is low, done is low and busy is low.
- R2: A word-mode access (req_word=1) performs exactly one memory cycle of CYC_CLKS clocks at req_addr. A word write stores all 20 bits of req_wdata. Done is high in the clock CYC_CLKS+1 clocks after the request clock.
- R3: Write enable goes low only during write cycles. In each write cycle it is low for CYC_CLKS-2 consecutive clocks, starting in the second clock of the cycle, and it is high in the first and last clocks.
- R4: The data output enable is high exactly while a write cycle is in progress. In three-byte mode, bits 19:8 of the driven data are zero.
- R5: Address and driven data hold the same value from the clock in which write enable falls through the clock in which it rises.
- R6: Between two write-enable low pulses, write enable stays high for at least two clocks.
- R7: A three-byte write puts bits 7:0 at base, bits 15:8 at base+1, and {4'b0000, bits 19:16} at base+2, in that order. Address arithmetic wraps modulo 2^16.
- R8: A three-byte read samples mem_dq_in[7:0] in the last clock of each byte cycle and assembles bits 7:0, 15:8 and 19:16 from base, base+1 and base+2. Bits 19:8 of the input are ignored, and so are bits 7:4 of the third byte.
- R9: A word read samples all 20 input bits in the last clock of its cycle. Read data is valid on rdata while done is high.
- R10: Done is a single-clock pulse, raised once per access, 3*CYC_CLKS+1 clocks after the request clock in three-byte mode.
- R11: Busy is high from the clock after an accepted request until done. A request presented while busy is ignored and starts no memory cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, one clock, accepted only when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word mode, 0 = three-byte mode |
| req_addr | input | 16 | Base address |
| req_wdata | input | 20 | Value to write |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 20 | Assembled read value, valid with done |
| mem_addr | output | 16 | Memory address |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 20 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Output enable for the data pads |
| mem_dq_in | input | 20 | Data returned by the memory |

## Verification
The hardest situation to reach from the ports is a second request that arrives partway through a three-byte transfer. The stimulus raises a request with a different address and mode in the middle of a byte write. It then checks that no extra cycle follows and that the sentinel word at the second address is untouched. The other hard case is garbage in the upper lanes during byte reads. The bench memory model preloads bits 19:8 of every byte location with junk, so a controller that uses those bits, or bits 7:4 of the third byte, returns a wrong word. A sweep over many addresses and data patterns runs every mode and direction. It includes a base address just below the 16-bit wrap point.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

   typedef enum logic {
      SBW_MODE_BYTES = 1'b0,
      SBW_MODE_WORD  = 1'b1
   } sbw_mode_e;

   function automatic int sbw_ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/sbw_seq.sv
module sbw_seq #(
   parameter int CYC_CLKS = 3,
   parameter int LANES    = 3,
   localparam int PH_W    = $clog2(CYC_CLKS),
   localparam int BT_W    = $clog2(LANES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            word_mode,
   output logic            active,
   output logic [BT_W-1:0] beat,
   output logic            last_phase,
   output logic            finish,
   output logic            strobe_win
);

   logic [PH_W-1:0] phase;
   logic [BT_W-1:0] last_beat;

   assign last_beat  = word_mode ? '0 : BT_W'(LANES - 1);
   assign last_phase = active && (phase == PH_W'(CYC_CLKS - 1));
   assign finish     = last_phase && (beat == last_beat);
   assign strobe_win = active && (phase != '0) && (phase != PH_W'(CYC_CLKS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         phase  <= '0;
         beat   <= '0;
      end else if (!active) begin
         if (start) begin
            active <= 1'b1;
            phase  <= '0;
            beat   <= '0;
         end
      end else if (last_phase) begin
         phase <= '0;
         if (beat == last_beat) begin
            active <= 1'b0;
            beat   <= '0;
         end else begin
            beat <= beat + 1'b1;
         end
      end else begin
         phase <= phase + 1'b1;
      end
   end

endmodule

// File: rtl/sbw_hold.sv
module sbw_hold #(
   parameter int DATA_W = 20,
   parameter int BYTE_W = 8,
   parameter int LANES  = 3,
   localparam int BT_W  = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] wdata,
   input  logic              capture,
   input  logic              word_mode,
   input  logic [BT_W-1:0]   beat,
   input  logic [DATA_W-1:0] rd_bus,
   output logic [DATA_W-1:0] hold,
   output logic [DATA_W-1:0] drive
);

   logic [BYTE_W-1:0] lane_pad [LANES];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int LO = l * BYTE_W;
      localparam int HI = ((LO + BYTE_W) > DATA_W) ? DATA_W : (LO + BYTE_W);
      localparam int LW = HI - LO;

      logic [LW-1:0] lane_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else if (load) begin
            lane_q <= wdata[HI-1:LO];
         end else if (capture) begin
            if (word_mode)
               lane_q <= rd_bus[HI-1:LO];
            else if (beat == BT_W'(l))
               lane_q <= rd_bus[LW-1:0];
         end
      end

      assign hold[HI-1:LO] = lane_q;
      assign lane_pad[l]   = BYTE_W'(lane_q);
   end

   always_comb begin
      if (word_mode)
         drive = hold;
      else
         drive = DATA_W'(lane_pad[beat]);
   end

endmodule

// File: rtl/sram_byteword_ctrl.sv
module sram_byteword_ctrl #(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 20,
   parameter int BYTE_W   = 8,
   parameter int CYC_CLKS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_write,
   input  logic              req_word,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int LANES = sbw_pkg::sbw_ceil_div(DATA_W, BYTE_W);
   localparam int BT_W  = $clog2(LANES);

   if (CYC_CLKS < 3) begin : g_bad_cyc
      $error("CYC_CLKS must be at least 3 to frame the write strobe");
   end
   if (LANES < 2) begin : g_bad_lanes
      $error("DATA_W must exceed BYTE_W");
   end
   if (LANES > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the lane count");
   end

   logic              active;
   logic [BT_W-1:0]   beat;
   logic              last_phase;
   logic              finish;
   logic              strobe_win;
   logic              accept;
   logic              wr_q;
   sbw_pkg::sbw_mode_e mode_q;
   logic [ADDR_W-1:0] base_q;
   logic [DATA_W-1:0] hold;
   logic              done_q;

   assign accept = req && !active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q   <= 1'b0;
         mode_q <= sbw_pkg::SBW_MODE_BYTES;
         base_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= finish;
         if (accept) begin
            wr_q   <= req_write;
            mode_q <= req_word ? sbw_pkg::SBW_MODE_WORD : sbw_pkg::SBW_MODE_BYTES;
            base_q <= req_addr;
         end
      end
   end

   sbw_seq #(
      .CYC_CLKS (CYC_CLKS),
      .LANES    (LANES)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .word_mode  (mode_q == sbw_pkg::SBW_MODE_WORD),
      .active     (active),
      .beat       (beat),
      .last_phase (last_phase),
      .finish     (finish),
      .strobe_win (strobe_win)
   );

   sbw_hold #(
      .DATA_W (DATA_W),
      .BYTE_W (BYTE_W),
      .LANES  (LANES)
   ) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .wdata     (req_wdata),
      .capture   (last_phase && !wr_q),
      .word_mode (mode_q == sbw_pkg::SBW_MODE_WORD),
      .beat      (beat),
      .rd_bus    (mem_dq_in),
      .hold      (hold),
      .drive     (mem_dq_out)
   );

   assign busy      = active;
   assign done      = done_q;
   assign rdata     = hold;
   assign mem_addr  = base_q + ADDR_W'(beat);
   assign mem_cs_n  = !active;
   assign mem_we_n  = !(strobe_win && wr_q);
   assign mem_dq_oe = active && wr_q;

endmodule

// File: rtl/sbw_checker.sv
module sbw_checker #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_cs_n,
   input logic              mem_we_n,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe
);

   // R3: strobe only inside a driven write cycle
   a_r3_we_only_write: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_dq_oe);

   // R4: pads driven only while the chip is selected
   a_r4_oe_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> !mem_cs_n);

   // R5: address and data held through the strobe rise
   a_r5_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

   // R6: minimum high time of the strobe
   a_r6_we_high_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |=> mem_we_n);

   // R10: done is one clock wide
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: done follows a memory cycle
   a_r10_done_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(!mem_cs_n));

   // R11: no request is taken while busy, so busy never drops without done
   a_r11_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

endmodule

bind sram_byteword_ctrl sbw_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_sbw_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .done       (done),
   .mem_addr   (mem_addr),
   .mem_cs_n   (mem_cs_n),
   .mem_we_n   (mem_we_n),
   .mem_dq_out (mem_dq_out),
   .mem_dq_oe  (mem_dq_oe)
);

// File: tb/test_sram_byteword_ctrl.sv
module test_sram_byteword_ctrl;

   localparam int C = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        req_write = 1'b0;
   logic        req_word = 1'b0;
   logic [15:0] req_addr = '0;
   logic [19:0] req_wdata = '0;
   logic        busy, done;
   logic [19:0] rdata;
   logic [15:0] mem_addr;
   logic        mem_cs_n, mem_we_n, mem_dq_oe;
   logic [19:0] mem_dq_out;
   logic [19:0] mem_dq_in;

   logic [19:0] mem [256];

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   sram_byteword_ctrl #(
      .ADDR_W (16), .DATA_W (20), .BYTE_W (8), .CYC_CLKS (C)
   ) i_sram_byteword_ctrl (
      .clk (clk), .rst_n (rst_n), .req (req), .req_write (req_write),
      .req_word (req_word), .req_addr (req_addr), .req_wdata (req_wdata),
      .busy (busy), .done (done), .rdata (rdata), .mem_addr (mem_addr),
      .mem_cs_n (mem_cs_n), .mem_we_n (mem_we_n), .mem_dq_out (mem_dq_out),
      .mem_dq_oe (mem_dq_oe), .mem_dq_in (mem_dq_in)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory model
   assign mem_dq_in = (!mem_cs_n && !mem_dq_oe) ? mem[mem_addr[7:0]] : 20'h0;
   always @(posedge mem_we_n) if (mem_cs_n === 1'b0) mem[mem_addr[7:0]] <= mem_dq_out;

   // strobe bookkeeping
   logic [15:0] fall_addr [4];
   logic [19:0] fall_data;
   logic [15:0] fall_a;
   int  nfall = 0;
   int  lowcnt = 0;
   int  highcnt = 0;
   bit  seen_pulse = 0;
   bit  cur_wr = 0;
   bit  cur_word = 0;

   always @(negedge mem_we_n) if (rst_n) begin
      fall_a    = mem_addr;
      fall_data = mem_dq_out;
      if (nfall < 4) fall_addr[nfall] = mem_addr;
      nfall++;
   end

   always @(posedge mem_we_n) if (rst_n && mem_cs_n === 1'b0) begin
      chk(mem_addr == fall_a, "R5 address held", 32'(mem_addr), 32'(fall_a));
      chk(mem_dq_out == fall_data, "R5 data held", 32'(mem_dq_out), 32'(fall_data));
   end

   always @(negedge clk) if (rst_n) begin
      if (!mem_we_n) begin
         if (lowcnt == 0 && seen_pulse)
            chk(highcnt >= 2, "R6 strobe high gap", 32'(highcnt), 32'd2);
         if (lowcnt == 0)
            chk(cur_wr, "R3 strobe in read", 32'(cur_wr), 32'd1);
         lowcnt++;
         highcnt = 0;
      end else begin
         if (lowcnt != 0) begin
            chk(lowcnt == C - 2, "R3 strobe width", 32'(lowcnt), 32'(C - 2));
            seen_pulse = 1;
         end
         lowcnt = 0;
         highcnt++;
      end
      if (mem_dq_oe && !cur_word)
         chk(mem_dq_out[19:8] == 12'h0, "R4 upper lanes zero", 32'(mem_dq_out[19:8]), 32'd0);
      if (mem_dq_oe)
         chk(cur_wr, "R4 oe in read", 32'(cur_wr), 32'd1);
   end

   task automatic do_op(input bit wr, input bit word, input logic [15:0] a,
                        input logic [19:0] d, output logic [19:0] rd, output int clks);
      @(negedge clk);
      cur_wr = wr; cur_word = word; nfall = 0;
      req = 1'b1; req_write = wr; req_word = word; req_addr = a; req_wdata = d;
      @(negedge clk);
      req = 1'b0;
      clks = 1;
      while (!done && clks < 200) begin
         @(negedge clk);
         clks++;
      end
      rd = rdata;
      @(negedge clk);
      chk(!done, "R10 done single pulse", 32'(done), 32'd0);
   endtask

   initial begin : watchdog
      #(20 * 150000);
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [19:0] rd;
      int clks;
      for (int k = 0; k < 256; k++) mem[k] = 20'h0;
      repeat (3) @(negedge clk);
      chk(mem_cs_n === 1'b1, "R1 cs after reset", 32'(mem_cs_n), 32'd1);
      chk(mem_we_n === 1'b1, "R1 we after reset", 32'(mem_we_n), 32'd1);
      chk(mem_dq_oe === 1'b0, "R1 oe after reset", 32'(mem_dq_oe), 32'd0);
      chk(done === 1'b0 && busy === 1'b0, "R1 done busy after reset", 32'({done, busy}), 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < 24; i++) begin
         logic [19:0] d;
         logic [15:0] wa, ba;
         d  = 20'((i * 32'h3A5C7 + 13) ^ (i << 15));
         wa = 16'(i * 5 + 1);
         ba = 16'h0080 + 16'(i * 3);
         // word write
         do_op(1, 1, wa, d, rd, clks);
         chk(clks == C + 1, "R2 word cycle length", 32'(clks), 32'(C + 1));
         chk(mem[wa[7:0]] == d, "R2 word stored", 32'(mem[wa[7:0]]), 32'(d));
         chk(nfall == 1, "R3 one strobe per word", 32'(nfall), 32'd1);
         // word read
         mem[wa[7:0]] = ~d;
         do_op(0, 1, wa, 20'h0, rd, clks);
         chk(rd == ~d, "R9 word read", 32'(rd), 32'(~d));
         chk(nfall == 0, "R3 no strobe on read", 32'(nfall), 32'd0);
         // three-byte write
         do_op(1, 0, ba, d, rd, clks);
         chk(clks == 3 * C + 1, "R10 byte access length", 32'(clks), 32'(3 * C + 1));
         chk(mem[ba[7:0]] == {12'h0, d[7:0]}, "R7 byte0", 32'(mem[ba[7:0]]), 32'(d[7:0]));
         chk(mem[8'(ba + 1)] == {12'h0, d[15:8]}, "R7 byte1", 32'(mem[8'(ba + 1)]), 32'(d[15:8]));
         chk(mem[8'(ba + 2)] == {16'h0, d[19:16]}, "R7 byte2", 32'(mem[8'(ba + 2)]), 32'(d[19:16]));
         chk(fall_addr[0] == ba && fall_addr[2] == ba + 2, "R7 byte order",
             32'({fall_addr[0], fall_addr[2]}), 32'({ba, 16'(ba + 2)}));
         // three-byte read with junk on upper lanes
         mem[ba[7:0]]      = mem[ba[7:0]]      | 20'hA5F00;
         mem[8'(ba + 1)]   = mem[8'(ba + 1)]   | 20'h5A300;
         mem[8'(ba + 2)]   = mem[8'(ba + 2)]   | 20'hC3DF0;
         do_op(0, 0, ba, 20'h0, rd, clks);
         chk(rd == d, "R8 byte read assembly", 32'(rd), 32'(d));
      end

      // address wrap
      do_op(1, 0, 16'hFFFE, 20'hBEEF1, rd, clks);
      chk(fall_addr[1] == 16'hFFFF && fall_addr[2] == 16'h0000, "R7 address wrap",
          32'({fall_addr[1], fall_addr[2]}), 32'h0000FFFF << 16);
      chk(mem[8'h00] == 20'h0000B, "R7 wrapped top byte", 32'(mem[8'h00]), 32'hB);

      // request while busy
      mem[8'h90] = 20'h12345;
      @(negedge clk);
      cur_wr = 1; cur_word = 0; nfall = 0;
      req = 1; req_write = 1; req_word = 0; req_addr = 16'h00A0; req_wdata = 20'h9C3E7;
      @(negedge clk);
      req = 0;
      repeat (3) @(negedge clk);
      chk(busy, "R11 busy mid transfer", 32'(busy), 32'd1);
      req = 1; req_write = 1; req_word = 1; req_addr = 16'h0090; req_wdata = 20'h0;
      @(negedge clk);
      req = 0;
      clks = 0;
      while (!done && clks < 200) begin @(negedge clk); clks++; end
      repeat (2 * C) begin
         @(negedge clk);
         chk(mem_cs_n, "R11 no extra cycle", 32'(mem_cs_n), 32'd1);
      end
      chk(mem[8'h90] == 20'h12345, "R11 ignored request", 32'(mem[8'h90]), 32'h12345);
      chk(nfall == 3, "R11 three strobes only", 32'(nfall), 32'd3);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule